// File: doc/BRIEF.md
# Reset Sequencer with Window Watchdog

This block gathers every reason a chip may need to restart into a single active-low reset line and remembers which of them fired. Power-on is an asynchronous input that resets the whole block; the external reset pin, a high-temperature detector and a low-voltage detector arrive as digital levels and pass through synchronisers. A window watchdog is the fifth source. The reset line behaves like an open-drain pin: a 0 on `rst_out_n` means "pull the pin low".

The internal sources (power-on, watchdog, high temperature, low voltage) keep the reset low while they are active and then for a further `STRETCH_CYC` clock cycles. The default is 62,500 cycles, which is 1.25 ms at 50 MHz. If an internal source comes back during that tail, the tail starts again. The external pin is already a reset line, so it holds the output only while it is asserted and adds no tail. A host-controlled mask bit can stop the temperature source from resetting the chip.

The sequencer is a three-state machine. HOLD holds the line low while any source is active. STRETCH counts the tail. RUN releases the line. Its transitions are:
- RUN to HOLD when any source appears.
- HOLD to STRETCH when the sources clear, if an internal source was seen.
- HOLD to RUN when the sources clear, if only the pin was seen.
- STRETCH to HOLD when a source returns.
- STRETCH to RUN when the count ends.

The watchdog machine has four states. OFF is its state before arming and after any reset. SHUT is the closed half of the period. OPEN is the open half. TRIP lasts one cycle and requests a reset. Its transitions are:
- OFF to SHUT on the arm strobe.
- SHUT to OPEN at mid-period.
- SHUT to TRIP on a clear attempt.
- OPEN to SHUT on a chip-select rising edge, when a clear was written in the open window.
- OPEN to TRIP at the end of the period.
- TRIP to OFF.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, `rst_out_n` is 0, `wd_armed` is 0 and `rst_status` equals 5'b00001 (bit 0 = power-on flag). After `por_n` rises, `rst_out_n` goes to 1 on the `STRETCH_CYC`-th rising clock edge. The power-on flag is never set by anything other than `por_n`.
- R2: `ext_rst_n` passes through a two-flop synchroniser. `rst_out_n` goes low two edges after the pin is first sampled low. It stays low for as many cycles as the pin was held low, with no added tail. The pin sets status bit 1.
- R3: `temp_high` and `volt_low` are synchronised the same way as the pin. Each holds `rst_out_n` low while it is active and for `STRETCH_CYC` cycles after it clears. `temp_high` sets status bit 3 and `volt_low` sets status bit 4.
- R4: An internal source that returns while the tail is running sends the sequencer back to HOLD. A full tail follows its next release.
- R5: While `htr_disable` is 1, `temp_high` has no effect on `rst_out_n` or on status bit 3.
- R6: Status flags stay set until cleared. Writing `status_wr`=1 clears exactly the bits that are 1 in `status_w1c`.
- R7: `wd_enable_set` arms the watchdog, and `wd_armed` reads 1. No input disarms it. Only a reset (`rst_out_n` low) clears `wd_armed`.
- R8: The watchdog period is divided into two halves. For the first half after arming or a restart, `wd_open` is 0 (closed). For the second half, `wd_open` is 1 (open).
- R9: A `wd_clear_wr` pulse sampled while the window is closed trips the watchdog at that edge. `rst_out_n` falls one cycle later.
- R10: A `wd_clear_wr` pulse sampled while the window is open is held pending. The counter restarts, closed, on the next rising edge of `spi_cs_n`. Without that edge, the period still runs out.
- R11: The period is (`wd_trim`+1)×`WD_UNIT` cycles. If the period ends without a restart, the watchdog trips on that edge.
- R12: A watchdog trip sets status bit 2 and holds `rst_out_n` low for 1+`STRETCH_CYC` cycles.
- R13: `wd_clear_wr` and `spi_cs_n` have no effect while the watchdog is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin level, active low, asynchronous |
| temp_high | input | 1 | Over-temperature detector level, asynchronous |
| volt_low | input | 1 | Under-voltage detector level, asynchronous |
| htr_disable | input | 1 | Mask bit: 1 blocks temperature resets |
| wd_enable_set | input | 1 | One-cycle strobe that arms the watchdog |
| wd_clear_wr | input | 1 | One-cycle strobe: host wrote 1 to the watchdog clear bit |
| spi_cs_n | input | 1 | Host transfer chip select; its rising edge commits a pending clear |
| wd_trim | input | TRIM_W | Watchdog period trim |
| status_wr | input | 1 | Status write strobe |
| status_w1c | input | 5 | Status bits to clear on write |
| rst_out_n | output | 1 | Reset line, 0 = drive the pin low |
| rst_status | output | 5 | Cause flags: 0 power-on, 1 pin, 2 watchdog, 3 temperature, 4 voltage |
| wd_armed | output | 1 | Watchdog armed |
| wd_open | output | 1 | Watchdog window open |

## Verification
Asynchronous sources reach `rst_out_n` three edges after they are first sampled: two synchroniser stages and the sequencer register. Pin releases follow with the same lag, and internal releases add `STRETCH_CYC` more. A watchdog trip registers on the edge that ends the period, or on the edge that samples an early clear, and lowers `rst_out_n` one edge later. Status bits update on the same edge as the sequencer. The bench drives and samples on falling clock edges, counts low samples of `rst_out_n` over windows long enough to hold each expected pulse, and checks `wd_open` and `rst_out_n` on exactly the cycle where a transition is due.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

    localparam int FLAG_W = 5;
    localparam int F_POR  = 0;
    localparam int F_PIN  = 1;
    localparam int F_WDOG = 2;
    localparam int F_HOT  = 3;
    localparam int F_LOWV = 4;

    typedef logic [FLAG_W-1:0] flags_t;

    localparam flags_t FLAGS_AFTER_POR = flags_t'(1) << F_POR;

    typedef enum logic [1:0] {
        SEQ_HOLD    = 2'd0,
        SEQ_STRETCH = 2'd1,
        SEQ_RUN     = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_SHUT = 2'd1,
        WD_OPEN = 2'd2,
        WD_TRIP = 2'd3
    } wd_state_t;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], d[g]};
                end
            end
            assign q[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rst_seq.sv
module rst_seq
    import rst_sup_pkg::*;
#(
    parameter int STRETCH_CYC = 62500
) (
    input  logic clk,
    input  logic arst_n,
    input  logic src_pin,
    input  logic src_int,
    output logic sys_rst_n
);

    localparam int CW = $clog2(STRETCH_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STRETCH_CYC - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          seen_q, seen_d;

    // state register; power-on enters the tail directly
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= SEQ_STRETCH;
            cnt_q   <= '0;
            seen_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            seen_q  <= seen_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        seen_d  = seen_q;
        unique case (state_q)
            SEQ_RUN: begin
                if (src_pin || src_int) begin
                    state_d = SEQ_HOLD;
                    seen_d  = src_int;
                end
            end
            SEQ_HOLD: begin
                if (src_int) begin
                    seen_d = 1'b1;
                end
                if (!src_pin && !src_int) begin
                    if (seen_q) begin
                        state_d = SEQ_STRETCH;
                        cnt_d   = '0;
                    end else begin
                        state_d = SEQ_RUN;
                    end
                end
            end
            SEQ_STRETCH: begin
                if (src_pin || src_int) begin
                    state_d = SEQ_HOLD;
                    seen_d  = 1'b1;
                end else if (cnt_q == LAST) begin
                    state_d = SEQ_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = SEQ_HOLD;
                seen_d  = 1'b1;
            end
        endcase
    end

    // output decode
    always_comb begin
        sys_rst_n = (state_q == SEQ_RUN);
    end

endmodule

// File: rtl/rst_wdog.sv
module rst_wdog
    import rst_sup_pkg::*;
#(
    parameter int TRIM_W  = 4,
    parameter int WD_UNIT = 1024
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              sys_rst,
    input  logic              en_set,
    input  logic              clr_wr,
    input  logic              cs_n,
    input  logic [TRIM_W-1:0] trim,
    output logic              fire,
    output logic              armed,
    output logic              win_open
);

    localparam int MAXP = (2 ** TRIM_W) * WD_UNIT;
    localparam int CW   = $clog2(MAXP + 1);

    wd_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] period_c, half_c;
    logic          armed_q, armed_d;
    logic          pend_q, pend_d;
    logic          cs_q;
    logic          cs_rise;

    always_comb begin
        period_c = CW'((32'(trim) + 32'd1) * 32'(WD_UNIT));
        half_c   = period_c >> 1;
        cs_rise  = cs_n && !cs_q;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q    <= WD_OFF;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
            cs_q    <= 1'b1;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            armed_q <= armed_d;
            pend_q  <= pend_d;
            cs_q    <= cs_n;
        end
    end

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        armed_d = armed_q;
        pend_d  = pend_q;
        if (sys_rst) begin
            st_d    = WD_OFF;
            cnt_d   = '0;
            armed_d = 1'b0;
            pend_d  = 1'b0;
        end else begin
            unique case (st_q)
                WD_OFF: begin
                    if (en_set && !armed_q) begin
                        armed_d = 1'b1;
                        st_d    = WD_SHUT;
                        cnt_d   = '0;
                    end
                end
                WD_SHUT: begin
                    if (clr_wr) begin
                        st_d = WD_TRIP;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == half_c - 1'b1) begin
                            st_d = WD_OPEN;
                        end
                    end
                end
                WD_OPEN: begin
                    if (cs_rise && (pend_q || clr_wr)) begin
                        st_d   = WD_SHUT;
                        cnt_d  = '0;
                        pend_d = 1'b0;
                    end else if (cnt_q == period_c - 1'b1) begin
                        st_d   = WD_TRIP;
                        pend_d = 1'b0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                        if (clr_wr) begin
                            pend_d = 1'b1;
                        end
                    end
                end
                WD_TRIP: begin
                    st_d   = WD_OFF;
                    pend_d = 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        fire     = (st_q == WD_TRIP);
        win_open = (st_q == WD_OPEN);
        armed    = armed_q;
    end

endmodule

// File: rtl/rst_status.sv
module rst_status
    import rst_sup_pkg::*;
(
    input  logic   clk,
    input  logic   arst_n,
    input  flags_t set_i,
    input  logic   wr_en,
    input  flags_t clr_mask,
    output flags_t flags_o
);

    flags_t flags_q;
    flags_t wipe;

    always_comb begin
        wipe = wr_en ? clr_mask : '0;
    end

    // setting wins over a simultaneous clear
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            flags_q <= FLAGS_AFTER_POR;
        end else begin
            flags_q <= (flags_q & ~wipe) | set_i;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rst_sup_pkg::*;
#(
    parameter int STRETCH_CYC = 62500,
    parameter int TRIM_W      = 4,
    parameter int WD_UNIT     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              temp_high,
    input  logic              volt_low,
    input  logic              htr_disable,
    input  logic              wd_enable_set,
    input  logic              wd_clear_wr,
    input  logic              spi_cs_n,
    input  logic [TRIM_W-1:0] wd_trim,
    input  logic              status_wr,
    input  logic [4:0]        status_w1c,
    output logic              rst_out_n,
    output logic [4:0]        rst_status,
    output logic              wd_armed,
    output logic              wd_open
);

    localparam int N_ASYNC = 3;

    logic [N_ASYNC-1:0] raw_src, sync_src;
    logic   pin_s, hot_s, lowv_s;
    logic   hot_eff, src_int;
    logic   wd_fire;
    logic   sys_rst_n;
    flags_t set_flags;

    assign raw_src = {volt_low, temp_high, ~ext_rst_n};

    rst_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (N_ASYNC)
    ) u_sync (
        .clk    (clk),
        .arst_n (por_n),
        .d      (raw_src),
        .q      (sync_src)
    );

    assign pin_s   = sync_src[0];
    assign hot_s   = sync_src[1];
    assign lowv_s  = sync_src[2];
    assign hot_eff = hot_s & ~htr_disable;
    assign src_int = hot_eff | lowv_s | wd_fire;

    rst_seq #(
        .STRETCH_CYC (STRETCH_CYC)
    ) u_seq (
        .clk       (clk),
        .arst_n    (por_n),
        .src_pin   (pin_s),
        .src_int   (src_int),
        .sys_rst_n (sys_rst_n)
    );

    rst_wdog #(
        .TRIM_W  (TRIM_W),
        .WD_UNIT (WD_UNIT)
    ) u_wdog (
        .clk      (clk),
        .arst_n   (por_n),
        .sys_rst  (~sys_rst_n),
        .en_set   (wd_enable_set),
        .clr_wr   (wd_clear_wr),
        .cs_n     (spi_cs_n),
        .trim     (wd_trim),
        .fire     (wd_fire),
        .armed    (wd_armed),
        .win_open (wd_open)
    );

    always_comb begin
        set_flags         = '0;
        set_flags[F_PIN]  = pin_s;
        set_flags[F_WDOG] = wd_fire;
        set_flags[F_HOT]  = hot_eff;
        set_flags[F_LOWV] = lowv_s;
    end

    rst_status u_status (
        .clk      (clk),
        .arst_n   (por_n),
        .set_i    (set_flags),
        .wr_en    (status_wr),
        .clr_mask (status_w1c),
        .flags_o  (rst_status)
    );

    assign rst_out_n = sys_rst_n;

endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk (
    input logic       clk,
    input logic       por_n,
    input logic       rst_out_n,
    input logic [4:0] rst_status,
    input logic       wd_armed,
    input logic       wd_fire,
    input logic       hot_s,
    input logic       lowv_s,
    input logic       htr_disable
);

    // R1: the power-on flag only appears through por_n
    assert_por_flag_R1: assert property (@(posedge clk) disable iff (!por_n)
        !$rose(rst_status[0]));

    // R3: a synchronised low-voltage level pulls the line low next cycle
    assert_lowv_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
        lowv_s |=> !rst_out_n);

    // R5: masked temperature never raises its flag
    assert_hot_masked_R5: assert property (@(posedge clk) disable iff (!por_n)
        (htr_disable && hot_s) |=> !$rose(rst_status[3]));

    // R7: arming survives while no reset is asserted
    assert_armed_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        (wd_armed && rst_out_n) |=> wd_armed);

    // R12: the watchdog flag only rises after a trip
    assert_wdr_cause_R12: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_status[2]) |-> $past(wd_fire));

endmodule

bind rst_supervisor rst_supervisor_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_out_n   (rst_out_n),
    .rst_status  (rst_status),
    .wd_armed    (wd_armed),
    .wd_fire     (wd_fire),
    .hot_s       (hot_s),
    .lowv_s      (lowv_s),
    .htr_disable (htr_disable)
);

// File: tb/rst_supervisor_bench.sv
`timescale 1ns/1ps
module rst_supervisor_bench;

    localparam int STRETCH = 8;
    localparam int TRIM_W  = 4;
    localparam int UNIT    = 8;

    // {kind[1:0], hold[7:0], expected low samples[7:0], expected status[4:0]}
    // kind: 0 pin, 1 temperature, 2 voltage, 3 temperature with mask set
    localparam logic [22:0] VEC [0:5] = '{
        {2'd0, 8'd3, 8'd3,  5'b00010},
        {2'd0, 8'd6, 8'd6,  5'b00010},
        {2'd1, 8'd2, 8'd10, 5'b01000},
        {2'd2, 8'd4, 8'd12, 5'b10000},
        {2'd3, 8'd5, 8'd0,  5'b00000},
        {2'd2, 8'd1, 8'd9,  5'b10000}
    };

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              ext_rst_n = 1'b1;
    logic              temp_high = 1'b0;
    logic              volt_low = 1'b0;
    logic              htr_disable = 1'b0;
    logic              wd_enable_set = 1'b0;
    logic              wd_clear_wr = 1'b0;
    logic              spi_cs_n = 1'b1;
    logic [TRIM_W-1:0] wd_trim = 4'd1;
    logic              status_wr = 1'b0;
    logic [4:0]        status_w1c = 5'd0;
    logic              rst_out_n;
    logic [4:0]        rst_status;
    logic              wd_armed;
    logic              wd_open;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    rst_supervisor #(
        .STRETCH_CYC (STRETCH),
        .TRIM_W      (TRIM_W),
        .WD_UNIT     (UNIT),
        .SYNC_STAGES (2)
    ) u_rst_supervisor (
        .clk           (clk),
        .por_n         (por_n),
        .ext_rst_n     (ext_rst_n),
        .temp_high     (temp_high),
        .volt_low      (volt_low),
        .htr_disable   (htr_disable),
        .wd_enable_set (wd_enable_set),
        .wd_clear_wr   (wd_clear_wr),
        .spi_cs_n      (spi_cs_n),
        .wd_trim       (wd_trim),
        .status_wr     (status_wr),
        .status_w1c    (status_w1c),
        .rst_out_n     (rst_out_n),
        .rst_status    (rst_status),
        .wd_armed      (wd_armed),
        .wd_open       (wd_open)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_src(input int kind, input logic on);
        case (kind)
            0: ext_rst_n = !on;
            1: temp_high = on;
            2: volt_low = on;
            3: begin htr_disable = 1'b1; temp_high = on; end
            default: ;
        endcase
    endtask

    task automatic pulse_src(input int kind, input int h);
        drive_src(kind, 1'b1);
        repeat (h) @(negedge clk);
        drive_src(kind, 1'b0);
    endtask

    task automatic count_low(input int win, output int n);
        n = 0;
        repeat (win) begin
            @(negedge clk);
            if (!rst_out_n) n++;
        end
    endtask

    task automatic clear_status(input logic [4:0] mask);
        status_wr  = 1'b1;
        status_w1c = mask;
        @(negedge clk);
        status_wr  = 1'b0;
        status_w1c = 5'd0;
    endtask

    task automatic arm_wd();
        wd_enable_set = 1'b1;
        @(negedge clk);
        wd_enable_set = 1'b0;
    endtask

    // k negedges into the period, write clear, then raise chip select
    task automatic service(input int k);
        repeat (k) @(negedge clk);
        wd_clear_wr = 1'b1;
        spi_cs_n    = 1'b0;
        @(negedge clk);
        wd_clear_wr = 1'b0;
        spi_cs_n    = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lows;

        // R1: reset state and power-on release
        repeat (3) @(negedge clk);
        chk("R1 rst_out_n during por", int'(rst_out_n), 0);
        chk("R1 status during por", int'(rst_status), 1);
        chk("R7 armed during por", int'(wd_armed), 0);
        por_n = 1'b1;
        count_low(STRETCH + 6, lows);
        chk("R1 low cycles after por release", lows, STRETCH - 1);
        chk("R1 status after release", int'(rst_status), 1);

        // vector table: source kinds, hold lengths, masking
        for (int i = 0; i < 6; i++) begin
            int    kind;
            string req;
            kind = int'(VEC[i][22:21]);
            req  = (kind == 0) ? "R2" : (kind == 3) ? "R5" : "R3";
            clear_status(5'h1F);
            fork
                pulse_src(kind, int'(VEC[i][20:13]));
                count_low(40, lows);
            join
            chk({req, " low cycles"}, lows, int'(VEC[i][12:5]));
            chk({req, " status flags"}, int'(rst_status), int'(VEC[i][4:0]));
            htr_disable = 1'b0;
        end

        // R4: source returns during the tail
        clear_status(5'h1F);
        fork
            begin
                pulse_src(1, 2);
                repeat (3) @(negedge clk);
                pulse_src(1, 2);
            end
            count_low(50, lows);
        join
        chk("R4 retriggered low cycles", lows, 15);

        // R6: flags accumulate, write-one-to-clear is per bit
        clear_status(5'h1F);
        fork pulse_src(0, 2); count_low(20, lows); join
        fork pulse_src(2, 2); count_low(20, lows); join
        chk("R6 accumulated flags", int'(rst_status), 5'b10010);
        clear_status(5'b00010);
        chk("R6 partial clear", int'(rst_status), 5'b10000);
        clear_status(5'b00000);
        chk("R6 zero mask keeps flags", int'(rst_status), 5'b10000);

        // R13: clear and chip select ignored when not armed
        clear_status(5'h1F);
        chk("R13 not armed", int'(wd_armed), 0);
        fork service(2); count_low(12, lows); join
        chk("R13 no reset from unarmed clear", lows, 0);
        chk("R13 status untouched", int'(rst_status), 0);

        // R7/R8/R10: arm, window edges, valid services
        arm_wd();
        chk("R7 armed after strobe", int'(wd_armed), 1);
        repeat (7) @(negedge clk);
        chk("R8 window closed at last closed cycle", int'(wd_open), 0);
        @(negedge clk);
        chk("R8 window open at half period", int'(wd_open), 1);
        service(2);
        chk("R10 restart closes window", int'(wd_open), 0);
        fork
            begin service(8); service(13); service(10); end
            count_low(36, lows);
        join
        chk("R10 serviced watchdog keeps reset high", lows, 0);
        chk("R10 no watchdog flag", int'(rst_status), 0);
        chk("R7 still armed", int'(wd_armed), 1);

        // R10: open-window clear without chip-select edge does not restart
        repeat (9) @(negedge clk);
        wd_clear_wr = 1'b1;
        spi_cs_n    = 1'b0;
        @(negedge clk);
        wd_clear_wr = 1'b0;
        count_low(30, lows);
        spi_cs_n = 1'b1;
        chk("R10 pending clear without cs edge trips", lows, STRETCH + 1);
        chk("R12 watchdog flag set", int'(rst_status), 5'b00100);
        chk("R7 reset disarms", int'(wd_armed), 0);

        // R11/R12: timeout at exact period, two trim values
        clear_status(5'h1F);
        arm_wd();
        repeat (16) @(negedge clk);
        chk("R11 high until period end trim=1", int'(rst_out_n), 1);
        @(negedge clk);
        chk("R11 low after period end trim=1", int'(rst_out_n), 0);
        count_low(20, lows);
        chk("R12 remaining low cycles", lows, STRETCH);
        chk("R12 flag after timeout", int'(rst_status), 5'b00100);

        clear_status(5'h1F);
        wd_trim = 4'd2;
        arm_wd();
        repeat (24) @(negedge clk);
        chk("R11 high until period end trim=2", int'(rst_out_n), 1);
        @(negedge clk);
        chk("R11 low after period end trim=2", int'(rst_out_n), 0);
        repeat (15) @(negedge clk);
        wd_trim = 4'd1;

        // R9: clear on last closed cycle trips immediately
        clear_status(5'h1F);
        arm_wd();
        repeat (7) @(negedge clk);
        wd_clear_wr = 1'b1;
        spi_cs_n    = 1'b0;
        @(negedge clk);
        wd_clear_wr = 1'b0;
        spi_cs_n    = 1'b1;
        chk("R9 line still high on trip edge", int'(rst_out_n), 1);
        @(negedge clk);
        chk("R9 line low one cycle after early clear", int'(rst_out_n), 0);
        repeat (15) @(negedge clk);
        chk("R9 watchdog flag after early clear", int'(rst_status), 5'b00100);
        chk("R9 disarmed after early clear", int'(wd_armed), 0);
        chk("R9 line released", int'(rst_out_n), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule